// File: doc/BRIEF.md
# USB Device OUT Packet Receiver

This block sits behind a USB line receiver and turns the serial line state into accepted OUT transactions. A separate clock-recovery stage supplies a one-cycle `bit_en` strobe for every bit time, along with the sampled differential level and a single-ended-zero flag. The block hunts for the synchronisation pattern and undoes the NRZI coding and the bit stuffing. It then assembles bytes, checks each packet identifier and decides whether a token targets this device.

An OUT or SETUP token that names the programmed device address and an enabled endpoint arms the receiver for the data packet that follows. That packet's payload is written byte by byte into the endpoint FIFO, tagged with the endpoint number. The two trailing CRC bytes are held back and never written. At the end of the packet the block checks the CRC16, the data toggle, the endpoint's maximum packet size and its stall state. It then raises a one-cycle completion pulse with a status code, plus a handshake request when the endpoint type calls for one.

Top module: `usb_rx_decoder`

## Requirements
- R1: After reset, `fifo_wr`, `done` and `hs_req` are low, and every endpoint expects DATA0 (toggle 0).
- R2: A packet starts after at least six NRZ zeros followed by a one (a line level change is an NRZ 0, no change is an NRZ 1). A zero that follows six ones is removed. Bytes are assembled LSB first. Every payload byte of an accepted data packet is written in order on `fifo_data`, with the endpoint on `fifo_ep`, and the two CRC bytes are never written.
- R3: A PID byte is accepted only if bits 7:4 equal the inverse of bits 3:0. A packet with any other PID byte is ignored and produces no write, completion or handshake.
- R4: A token is accepted only if its PID is OUT (0001) or SETUP (1101), its 7-bit address (first bits after the PID) equals `dev_addr`, its 4-bit endpoint is below NEP with its `ep_enable` bit set, and its CRC5 (x^5+x^2+1) leaves residual 01100. Only then is the next DATA0 (0011) or DATA1 (1011) packet processed.
- R5: A data packet whose CRC16 (x^16+x^15+x^2+1) does not leave residual 0x800D completes with status CRC (1) and requests no handshake.
- R6: On a non-isochronous endpoint, a data packet whose toggle (PID bit 3) differs from the expected toggle completes with status TOGGLE (3), writes nothing and requests ACK (1). A good packet completes with status OK (0), requests ACK and flips the expected toggle.
- R7: A payload longer than the endpoint's `ep_max` field completes with status OVERSIZE (2), and only the first `ep_max` bytes are written. A NAK (2) is requested on non-isochronous endpoints.
- R8: An endpoint with its `ep_iso` bit set never gets a handshake request, and its toggle is not checked.
- R9: A data packet for an endpoint with its `ep_stall` bit set writes nothing, completes with status STALL (4) and requests STALL (3) on a non-isochronous endpoint.
- R10: Seven NRZ ones in a row within a packet discard the packet with no completion and no handshake. The next packet is received normally.
- R11: An accepted SETUP token resets the expected toggle of its endpoint to DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per recovered bit time |
| rx_d | input | 1 | Sampled differential level (1 = idle J) |
| rx_se0 | input | 1 | Both lines low (end of packet) |
| dev_addr | input | 7 | Device address |
| ep_enable | input | NEP | Endpoint enable mask |
| ep_stall | input | NEP | Endpoint stall mask |
| ep_iso | input | NEP | Endpoint is isochronous |
| ep_max | input | NEP*MW | Maximum payload per endpoint, endpoint n at bits n*MW upward |
| fifo_wr | output | 1 | Payload byte write strobe |
| fifo_ep | output | 4 | Endpoint of the written byte |
| fifo_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle data packet completion pulse |
| done_ep | output | 4 | Endpoint of the completed packet |
| done_status | output | 3 | 0 OK, 1 CRC, 2 OVERSIZE, 3 TOGGLE, 4 STALL |
| hs_req | output | 1 | Handshake request pulse, same cycle as `done` |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |

## Verification
The riskiest internal state is the per-endpoint expected toggle. A wrong value stays invisible until the next data packet to that endpoint, which then reports TOGGLE with no writes instead of OK, or the reverse. The bench therefore sends the same toggle twice in a row and also follows a SETUP with DATA0. An armed flag that is left stale shows up only when a later packet whose token was rejected still produces writes. A stuff counter that is off by one either corrupts bytes written a few bit times later or loses a whole packet, and bytes containing long runs of ones exercise this.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_SETUP = 4'b1101;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  localparam logic [4:0]  CRC5_RESID  = 5'b01100;
  localparam logic [15:0] CRC16_RESID = 16'h800D;

  typedef enum logic [2:0] {
    RX_OK       = 3'd0,
    RX_CRC      = 3'd1,
    RX_OVERSIZE = 3'd2,
    RX_TOGGLE   = 3'd3,
    RX_STALL    = 3'd4
  } rx_status_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // One serial step of the token CRC, x^5 + x^2 + 1.
  function automatic logic [4:0] crc5_step(logic [4:0] c, logic b);
    logic fb;
    fb = b ^ c[4];
    return {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
  endfunction

  // One serial step of the data CRC, x^16 + x^15 + x^2 + 1.
  function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
  endfunction

  function automatic logic pid_valid(logic [7:0] p);
    return p[7:4] == ~p[3:0];
  endfunction

endpackage

// File: rtl/usb_rx_line.sv
module usb_rx_line #(
  parameter int SYNC_ZEROS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_d,
  input  logic rx_se0,
  output logic sop,
  output logic bit_vld,
  output logic bit_val,
  output logic eop,
  output logic stuff_err
);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);

  typedef enum logic [1:0] {L_HUNT, L_ACTIVE, L_DROP} lstate_e;

  lstate_e        st;
  logic [ZW-1:0]  zcnt;
  logic [2:0]     ones;
  logic           prev_lvl;
  logic           nrz;

  assign nrz = (rx_d == prev_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= L_HUNT;
      zcnt      <= '0;
      ones      <= '0;
      prev_lvl  <= 1'b1;
      sop       <= 1'b0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      eop       <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      sop       <= 1'b0;
      bit_vld   <= 1'b0;
      eop       <= 1'b0;
      stuff_err <= 1'b0;
      if (bit_en) begin
        if (rx_se0) begin
          eop      <= (st == L_ACTIVE);
          st       <= L_HUNT;
          prev_lvl <= 1'b1;
          zcnt     <= '0;
        end else begin
          prev_lvl <= rx_d;
          case (st)
            L_HUNT: begin
              if (!nrz) begin
                if (zcnt != ZW'(SYNC_ZEROS)) zcnt <= zcnt + 1'b1;
              end else begin
                if (zcnt == ZW'(SYNC_ZEROS)) begin
                  st   <= L_ACTIVE;
                  sop  <= 1'b1;
                  ones <= 3'd1;
                end
                zcnt <= '0;
              end
            end
            L_ACTIVE: begin
              if (ones == 3'd6) begin
                if (nrz) begin
                  stuff_err <= 1'b1;
                  st        <= L_DROP;
                end
                ones <= '0;
              end else begin
                bit_vld <= 1'b1;
                bit_val <= nrz;
                ones    <= nrz ? ones + 1'b1 : 3'd0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R10: the run counter never passes six, so a seventh one is always caught
  a_r10_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd6);

  // R10: once a stuff error is seen, no bit and no end of packet leave this stage
  a_r10_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> (!bit_vld && !eop));

  // R2: start of packet and data bits never share a cycle
  a_r2_sop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    sop |-> (!bit_vld && !eop));

endmodule

// File: rtl/usb_rx_crc.sv
module usb_rx_crc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic crc5_ok,
  output logic crc16_ok
);
  import usb_rx_pkg::*;

  logic [4:0]  c5;
  logic [15:0] c16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c5  <= '1;
      c16 <= '1;
    end else if (clr) begin
      c5  <= '1;
      c16 <= '1;
    end else if (en) begin
      c5  <= crc5_step(c5, bit_in);
      c16 <= crc16_step(c16, bit_in);
    end
  end

  assign crc5_ok  = (c5 == CRC5_RESID);
  assign crc16_ok = (c16 == CRC16_RESID);

endmodule

// File: rtl/usb_rx_decoder.sv
module usb_rx_decoder #(
  parameter int NEP    = 4,
  parameter int MAXPKT = 64,
  parameter int MW     = $clog2(MAXPKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_d,
  input  logic              rx_se0,
  input  logic [6:0]        dev_addr,
  input  logic [NEP-1:0]    ep_enable,
  input  logic [NEP-1:0]    ep_stall,
  input  logic [NEP-1:0]    ep_iso,
  input  logic [NEP*MW-1:0] ep_max,
  output logic              fifo_wr,
  output logic [3:0]        fifo_ep,
  output logic [7:0]        fifo_data,
  output logic              done,
  output logic [3:0]        done_ep,
  output logic [2:0]        done_status,
  output logic              hs_req,
  output logic [1:0]        hs_code
);
  import usb_rx_pkg::*;

  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1;
  localparam int NBW = $clog2(MAXPKT + 3) + 1;

  typedef enum logic [2:0] {T_IDLE, T_PID, T_TOK, T_DATA, T_SKIP} tstate_e;

  logic sop, bit_vld, bit_val, eop, stuff_err;
  logic crc5_ok, crc16_ok;

  usb_rx_line u_line (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_d(rx_d), .rx_se0(rx_se0),
    .sop(sop), .bit_vld(bit_vld), .bit_val(bit_val), .eop(eop), .stuff_err(stuff_err)
  );

  tstate_e          st;
  logic [7:0]       sh;
  logic [2:0]       bcnt;
  logic [NBW-1:0]   nb;
  logic [3:0]       pid_q;
  logic [15:0]      tok_q;
  logic [7:0]       d1, d2;
  logic             armed;
  logic [3:0]       arm_ep, cur_ep;
  logic             wr_ok;
  logic [NEP-1:0]   tog;
  logic [NBW-1:0]   wr_in_pkt;

  usb_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(sop),
    .en(bit_vld && (st == T_TOK || st == T_DATA)),
    .bit_in(bit_val), .crc5_ok(crc5_ok), .crc16_ok(crc16_ok)
  );

  // Per-endpoint maximum payload fields.
  logic [MW-1:0] max_arr [NEP];
  for (genvar g = 0; g < NEP; g++) begin : g_max
    assign max_arr[g] = ep_max[g*MW +: MW];
  end

  // Named internal events.
  logic [7:0]     new_byte;
  logic           byte_done, pid_done, tok_eop, data_eop_ok, tog_flip_evt;
  logic [6:0]     addr_rx;
  logic [3:0]     ep_rx;
  logic           tok_ep_ok, tok_accept;
  logic [EPW-1:0] cur_idx;
  logic [NBW-1:0] cur_max, payload;
  logic           cur_iso, wr_slot;
  rx_status_e     outcome;
  hs_e            hs_c;

  assign new_byte    = {bit_val, sh[7:1]};
  assign byte_done   = bit_vld && (bcnt == 3'd7);
  assign pid_done    = byte_done && (st == T_PID);
  assign addr_rx     = tok_q[6:0];
  assign ep_rx       = tok_q[10:7];
  assign tok_ep_ok   = (int'(ep_rx) < NEP) && ep_enable[ep_rx[EPW-1:0]];
  assign tok_eop     = eop && (st == T_TOK);
  assign tok_accept  = tok_eop && (bcnt == 3'd0) && (nb == NBW'(2)) && crc5_ok &&
                       (addr_rx == dev_addr) && tok_ep_ok;
  assign cur_idx     = cur_ep[EPW-1:0];
  assign cur_max     = NBW'(max_arr[cur_idx]);
  assign cur_iso     = ep_iso[cur_idx];
  assign payload     = nb - NBW'(2);
  assign wr_slot     = (nb >= NBW'(2)) && wr_ok && (payload < cur_max);
  assign data_eop_ok = eop && (st == T_DATA) && (bcnt == 3'd0) && (nb >= NBW'(2));
  assign tog_flip_evt = data_eop_ok && (outcome == RX_OK) && !cur_iso;

  always_comb begin
    if (ep_stall[cur_idx])                       outcome = RX_STALL;
    else if (!crc16_ok)                          outcome = RX_CRC;
    else if (payload > cur_max)                  outcome = RX_OVERSIZE;
    else if (!cur_iso && (pid_q[3] != tog[cur_idx])) outcome = RX_TOGGLE;
    else                                         outcome = RX_OK;
    if (cur_iso) hs_c = HS_NONE;
    else begin
      case (outcome)
        RX_STALL:    hs_c = HS_STALL;
        RX_CRC:      hs_c = HS_NONE;
        RX_OVERSIZE: hs_c = HS_NAK;
        default:     hs_c = HS_ACK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; sh <= '0; bcnt <= '0; nb <= '0; pid_q <= '0; tok_q <= '0;
      d1 <= '0; d2 <= '0; armed <= 1'b0; arm_ep <= '0; cur_ep <= '0; wr_ok <= 1'b0;
      tog <= '0; wr_in_pkt <= '0;
      fifo_wr <= 1'b0; fifo_ep <= '0; fifo_data <= '0;
      done <= 1'b0; done_ep <= '0; done_status <= '0; hs_req <= 1'b0; hs_code <= '0;
    end else begin
      fifo_wr <= 1'b0;
      done    <= 1'b0;
      hs_req  <= 1'b0;
      if (stuff_err) begin
        st    <= T_IDLE;
        armed <= 1'b0;
      end else if (sop) begin
        st   <= T_PID;
        bcnt <= '0;
      end else if (eop) begin
        st <= T_IDLE;
        if (st == T_TOK) begin
          armed <= tok_accept;
          if (tok_accept) begin
            arm_ep <= ep_rx;
            if (pid_q == PID_SETUP) tog[ep_rx[EPW-1:0]] <= 1'b0;
          end
        end else if (st == T_DATA) begin
          armed <= 1'b0;
          if (data_eop_ok) begin
            done        <= 1'b1;
            done_ep     <= cur_ep;
            done_status <= outcome;
            hs_req      <= (hs_c != HS_NONE);
            hs_code     <= hs_c;
            if (tog_flip_evt) tog[cur_idx] <= ~tog[cur_idx];
          end
        end
      end else if (bit_vld) begin
        sh   <= new_byte;
        bcnt <= bcnt + 1'b1;
        if (byte_done) begin
          if (nb != '1) nb <= nb + 1'b1;
          case (st)
            T_PID: begin
              pid_q     <= new_byte[3:0];
              nb        <= '0;
              wr_in_pkt <= '0;
              if (!pid_valid(new_byte)) st <= T_SKIP;
              else if (new_byte[3:0] == PID_OUT || new_byte[3:0] == PID_SETUP) st <= T_TOK;
              else if ((new_byte[3:0] == PID_DATA0 || new_byte[3:0] == PID_DATA1) && armed) begin
                st     <= T_DATA;
                cur_ep <= arm_ep;
                wr_ok  <= !ep_stall[arm_ep[EPW-1:0]] &&
                          (ep_iso[arm_ep[EPW-1:0]] || (new_byte[3] == tog[arm_ep[EPW-1:0]]));
              end else st <= T_SKIP;
            end
            T_TOK: tok_q <= {new_byte, tok_q[15:8]};
            T_DATA: begin
              d1 <= new_byte;
              d2 <= d1;
              if (wr_slot) begin
                fifo_wr   <= 1'b1;
                fifo_ep   <= cur_ep;
                fifo_data <= d2;
                wr_in_pkt <= wr_in_pkt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8: a handshake is only ever requested together with a completion
  a_r8_hs_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |-> done);

  // R5: a CRC failure never asks for a handshake
  a_r5_crc_no_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == RX_CRC) |-> !hs_req);

  // R7: writes in one packet never exceed the endpoint maximum
  a_r7_write_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_in_pkt <= cur_max));

  // R9: a stalled endpoint receives no bytes
  a_r9_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == RX_STALL) |-> (wr_in_pkt == '0));

  // R6: a toggle mismatch writes nothing
  a_r6_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == RX_TOGGLE) |-> (wr_in_pkt == '0));

  // R6: a good packet changes the expected toggle on the next cycle
  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    tog_flip_evt |=> (tog != $past(tog)));

endmodule

// File: tb/tb_usb_rx_decoder.sv
module tb_usb_rx_decoder;
  localparam int NEP = 4;
  localparam int MW  = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bit_en, rx_d, rx_se0;
  logic [6:0] dev_addr;
  logic [NEP-1:0] ep_enable, ep_stall, ep_iso;
  logic [NEP*MW-1:0] ep_max;
  logic fifo_wr, done, hs_req;
  logic [3:0] fifo_ep, done_ep;
  logic [7:0] fifo_data;
  logic [2:0] done_status;
  logic [1:0] hs_code;

  usb_rx_decoder #(.NEP(NEP), .MAXPKT(64)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_d(rx_d), .rx_se0(rx_se0),
    .dev_addr(dev_addr), .ep_enable(ep_enable), .ep_stall(ep_stall), .ep_iso(ep_iso),
    .ep_max(ep_max), .fifo_wr(fifo_wr), .fifo_ep(fifo_ep), .fifo_data(fifo_data),
    .done(done), .done_ep(done_ep), .done_status(done_status),
    .hs_req(hs_req), .hs_code(hs_code)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Observed events.
  logic [7:0] wr_d [0:255];
  logic [3:0] wr_e [0:255];
  int wr_n = 0, done_n = 0, hs_n = 0;
  logic [2:0] last_st;
  logic [3:0] last_ep;
  logic [1:0] last_hs;

  always @(negedge clk) if (rst_n) begin
    if (fifo_wr) begin
      wr_d[wr_n[7:0]] = fifo_data;
      wr_e[wr_n[7:0]] = fifo_ep;
      wr_n++;
    end
    if (done) begin done_n++; last_st = done_status; last_ep = done_ep; end
    if (hs_req) begin hs_n++; last_hs = hs_code; end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bit queue in NRZ order, with a per-bit "do not stuff" marker.
  logic bq [0:1023];
  logic nos [0:1023];
  int nbq;
  logic [7:0] pay [0:15];

  task automatic q_bit(logic b, logic raw);
    bq[nbq] = b; nos[nbq] = raw; nbq++;
  endtask

  task automatic q_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) q_bit(b[i], 1'b0);
  endtask

  function automatic logic [4:0] bcrc5(int s, int n);
    logic [4:0] r = 5'h1f;
    for (int i = s; i < s + n; i++) r = (bq[i] ^ r[4]) ? ((r << 1) ^ 5'h05) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] bcrc16(int s, int n);
    logic [15:0] r = 16'hffff;
    for (int i = s; i < s + n; i++) r = (bq[i] ^ r[15]) ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  task automatic send_lvl(logic l, logic s);
    rx_d = l; rx_se0 = s; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Sync, stuffing, NRZI, then end of packet and a settle period.
  task automatic tx_queue();
    logic lvl = 1'b1;
    int ones = 1;
    for (int i = 0; i < 7; i++) begin lvl = ~lvl; send_lvl(lvl, 1'b0); end
    send_lvl(lvl, 1'b0);
    for (int i = 0; i < nbq; i++) begin
      if (!bq[i]) lvl = ~lvl;
      send_lvl(lvl, 1'b0);
      ones = bq[i] ? ones + 1 : 0;
      if (ones == 6 && !nos[i]) begin lvl = ~lvl; send_lvl(lvl, 1'b0); ones = 0; end
    end
    send_lvl(1'b0, 1'b1);
    send_lvl(1'b0, 1'b1);
    send_lvl(1'b1, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic send_token(logic [3:0] pid, logic [6:0] addr, logic [3:0] ep, bit bad_crc, bit bad_pid);
    logic [4:0] c;
    nbq = 0;
    q_byte(bad_pid ? {pid, pid} : {~pid, pid});
    for (int i = 0; i < 7; i++) q_bit(addr[i], 1'b0);
    for (int i = 0; i < 4; i++) q_bit(ep[i], 1'b0);
    c = ~bcrc5(8, 11);
    if (bad_crc) c[0] = ~c[0];
    for (int i = 4; i >= 0; i--) q_bit(c[i], 1'b0);
    tx_queue();
  endtask

  task automatic send_data(logic [3:0] pid, int n, bit bad_crc);
    logic [15:0] c;
    nbq = 0;
    q_byte({~pid, pid});
    for (int k = 0; k < n; k++) q_byte(pay[k]);
    c = ~bcrc16(8, 8 * n);
    if (bad_crc) c[3] = ~c[3];
    for (int i = 15; i >= 0; i--) q_bit(c[i], 1'b0);
    tx_queue();
  endtask

  // OUT token to this device then one data packet; compare the deltas.
  task automatic xfer(string req, logic [3:0] tpid, logic [3:0] ep, logic [3:0] dpid, int n,
                      bit bad_crc, int exp_done, int exp_st, int exp_hs, int exp_wr);
    int w0 = wr_n, d0 = done_n, h0 = hs_n;
    send_token(tpid, dev_addr, ep, 1'b0, 1'b0);
    send_data(dpid, n, bad_crc);
    chk(req, "completions", done_n - d0, exp_done);
    if (exp_done == 1) begin
      chk(req, "status", int'(last_st), exp_st);
      chk(req, "done_ep", int'(last_ep), int'(ep));
    end
    chk(req, "handshakes", hs_n - h0, exp_hs == 0 ? 0 : 1);
    if (exp_hs != 0 && hs_n - h0 == 1) chk(req, "hs_code", int'(last_hs), exp_hs);
    chk(req, "writes", wr_n - w0, exp_wr);
    for (int k = 0; k < exp_wr && k < wr_n - w0; k++) begin
      chk(req, "write data", int'(wr_d[(w0 + k) % 256]), int'(pay[k]));
      chk(req, "write ep", int'(wr_e[(w0 + k) % 256]), int'(ep));
    end
  endtask

  task automatic set_max(int ep, int v);
    ep_max[ep*MW +: MW] = MW'(v);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1", "fifo_wr after reset", int'(fifo_wr), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "hs_req after reset", int'(hs_req), 0);
  endtask

  task automatic t_good();
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'hFF; pay[3] = 8'h7E;
    xfer("R2", 4'b0001, 4'd1, 4'b0011, 4, 1'b0, 1, 0, 1, 4);
  endtask

  task automatic t_toggle();
    pay[0] = 8'h11;
    xfer("R6", 4'b0001, 4'd1, 4'b1011, 1, 1'b0, 1, 3, 1, 0); // repeated DATA1 after flip back? see below
  endtask

  task automatic t_filter();
    int w0 = wr_n, d0 = done_n, h0 = hs_n;
    pay[0] = 8'h55;
    send_token(4'b0001, 7'h11, 4'd1, 1'b0, 1'b0); send_data(4'b0011, 1, 1'b0);
    send_token(4'b0001, dev_addr, 4'd2, 1'b0, 1'b0); send_data(4'b0011, 1, 1'b0);
    send_token(4'b0001, dev_addr, 4'd6, 1'b0, 1'b0); send_data(4'b0011, 1, 1'b0);
    send_token(4'b0001, dev_addr, 4'd1, 1'b1, 1'b0); send_data(4'b0011, 1, 1'b0);
    chk("R4", "completions from rejected tokens", done_n - d0, 0);
    chk("R4", "writes from rejected tokens", wr_n - w0, 0);
    chk("R4", "handshakes from rejected tokens", hs_n - h0, 0);
    send_token(4'b0001, dev_addr, 4'd1, 1'b0, 1'b1); send_data(4'b0011, 1, 1'b0);
    chk("R3", "completions after bad PID", done_n - d0, 0);
    chk("R3", "writes after bad PID", wr_n - w0, 0);
  endtask

  task automatic t_stuff();
    int d0 = done_n, h0 = hs_n;
    send_token(4'b0001, dev_addr, 4'd1, 1'b0, 1'b0);
    nbq = 0;
    q_byte(8'hC3);
    for (int i = 0; i < 7; i++) q_bit(1'b1, 1'b1);
    q_byte(8'h00);
    tx_queue();
    chk("R10", "completions after stuff error", done_n - d0, 0);
    chk("R10", "handshakes after stuff error", hs_n - h0, 0);
    pay[0] = 8'h5A;
    xfer("R10", 4'b0001, 4'd1, 4'b0011, 1, 1'b0, 1, 0, 1, 1);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_d = 1'b1; rx_se0 = 1'b0;
    dev_addr = 7'h2A; ep_enable = 4'b1011; ep_stall = '0; ep_iso = 4'b1000;
    ep_max = '0;
    set_max(0, 64); set_max(1, 8); set_max(2, 8); set_max(3, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // R2, R6: good DATA0, expected toggle becomes 1
    t_good();
    // R6: DATA0 again -> mismatch, ACK, no writes
    pay[0] = 8'h11;
    xfer("R6", 4'b0001, 4'd1, 4'b0011, 1, 1'b0, 1, 3, 1, 0);
    // R6: DATA1 accepted, toggle back to 0
    pay[0] = 8'h22; pay[1] = 8'h33;
    xfer("R6", 4'b0001, 4'd1, 4'b1011, 2, 1'b0, 1, 0, 1, 2);
    t_filter();
    // R5: bad CRC16, no handshake, toggle kept at 0
    pay[0] = 8'h44;
    xfer("R5", 4'b0001, 4'd1, 4'b0011, 1, 1'b1, 1, 1, 0, 1);
    // R7: oversize on a bulk endpoint
    set_max(1, 4);
    for (int k = 0; k < 6; k++) pay[k] = 8'(8'h80 + k);
    xfer("R7", 4'b0001, 4'd1, 4'b0011, 6, 1'b0, 1, 2, 2, 4);
    set_max(1, 8);
    // R8: oversize on an isochronous endpoint, then a fitting one with either toggle
    for (int k = 0; k < 3; k++) pay[k] = 8'(8'hF0 + k);
    xfer("R8", 4'b0001, 4'd3, 4'b0011, 3, 1'b0, 1, 2, 0, 2);
    xfer("R8", 4'b0001, 4'd3, 4'b1011, 2, 1'b0, 1, 0, 0, 2);
    // R9: stall
    ep_stall[1] = 1'b1;
    pay[0] = 8'h01;
    xfer("R9", 4'b0001, 4'd1, 4'b0011, 1, 1'b0, 1, 4, 3, 0);
    ep_stall[1] = 1'b0;
    // R10: stuff error, then recovery with DATA0 (toggle now 1)
    t_stuff();
    // R11: SETUP resets the toggle; DATA0 accepted although 1 was expected
    pay[0] = 8'h77;
    xfer("R11", 4'b1101, 4'd1, 4'b0011, 1, 1'b0, 1, 0, 1, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule